// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on one channel's 16-bit output path, after the converter datapath. On every sample clock it either forwards the converter's sample word or puts a deterministic test word in its place. A 3-bit mode code selects the word. The modes are live data, three fixed levels, two alternating patterns and two pseudo-random sequences of different lengths. Downstream capture logic can check these words to prove the output bus and the sampling alignment without a known analog input.

Each pseudo-random generator has its own clear input, so one sequence can be restarted without disturbing the other. Each channel carries its own instance with its own mode and clears, so two channels can show different patterns at the same time. The output word is offset binary and is held in a register, which gives one sample of latency from the inputs to the output.

Top module: `adc_test_pattern_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, `data_out` becomes 0x0000, both generators return to the all-ones seed and the alternation phase returns to its first half.
- R2: Mode code 0 forwards the sample word: `data_out` equals `sample_in` from the previous clock edge.
- R3: Mode code 1 gives 0x8000 (midscale), code 2 gives 0xFFFF (positive full scale) and code 3 gives 0x0000 (negative full scale).
- R4: Mode code 4 gives a checkerboard. The phase flips on every clock out of reset, whatever the mode. The first sample after reset and every second sample after it give 0xAAAA. The samples in between give 0x5555.
- R5: Mode code 7 gives the one/zero toggle. It uses the same phase as R4, with 0xFFFF in place of 0xAAAA and 0x0000 in place of 0x5555.
- R6: Mode code 5 gives the long sequence from a 23-bit shift register (x^23+x^18+1). Each step takes feedback = bit22 XOR bit17, shifts the register left and loads the feedback into bit 0. Each sample performs 16 steps. The output word holds the 16 feedback bits in order, with the first bit in bit 15. The generator advances on every sample, whatever the mode.
- R7: Mode code 6 gives the short sequence from a 9-bit register (x^9+x^5+1). Its feedback is bit8 XOR bit4, and it is otherwise built as in R6.
- R8: While a generator's clear input is high, that generator stays at the all-ones seed, so its word repeats. The long seed word is 0x0000. The first word after the clear falls is the seed word, and the generator then advances.
- R9: Each clear input affects only its own generator.
- R10: A change of mode code shows on `data_out` at the next clock edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_in | input | 16 | Converter sample word |
| mode_sel | input | 3 | Output pattern mode code |
| pn_long_clr | input | 1 | Hold the long generator at its seed |
| pn_short_clr | input | 1 | Hold the short generator at its seed |
| data_out | output | 16 | Registered output word |

## Verification
A wrong generator state shows at the ports only while that generator's mode is selected. Because the generators run freely, a state error made in any mode shows as a wrong word on the first sample after switching to that sequence, and it stays wrong from then on. A phase error shows as a swapped pair of words in the first alternating sample. An error in the clear or seed logic shows in the first word after the clear is released. The bench therefore moves between modes, clears each generator while the other runs, and compares every output sample against the reference model.

// File: rtl/tpg_pkg.sv
// Shared constants and mode encoding for the output test pattern generator.
// Assumes a 16-bit output word; the generator shapes are fixed by the requirements.
package tpg_pkg;
    localparam int DATA_W      = 16;
    localparam int MODE_W      = 3;
    localparam int LONG_LEN    = 23;
    localparam int LONG_TAP    = 18;
    localparam int SHORT_LEN   = 9;
    localparam int SHORT_TAP   = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_LIVE     = 3'd0,
        MODE_MID      = 3'd1,
        MODE_POS_FS   = 3'd2,
        MODE_NEG_FS   = 3'd3,
        MODE_CHECKER  = 3'd4,
        MODE_PN_LONG  = 3'd5,
        MODE_PN_SHORT = 3'd6,
        MODE_ONE_ZERO = 3'd7
    } tp_mode_e;
endpackage

// File: rtl/lfsr_word_gen.sv
// Fibonacci shift-register generator that makes WORD_W bits per sample.
// Polynomial x^STATE_W + x^TAP + 1. Seed is all ones; clr holds the seed.
// The word shown is the set of bits produced by advancing the current state.
// Assumes TAP < STATE_W.
module lfsr_word_gen #(
    parameter int STATE_W = 23,
    parameter int TAP     = 18,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [STATE_W-1:0] SEED   = '1;
    localparam int                 FB_HI  = STATE_W - 1;
    localparam int                 FB_LO  = TAP - 1;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_nxt;
    logic [WORD_W-1:0]  word_nxt;

    // Unroll WORD_W single-bit steps from the current state
    always_comb begin
        logic [STATE_W-1:0] s;
        logic               fb;
        s        = state_q;
        word_nxt = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb       = s[FB_HI] ^ s[FB_LO];
            s        = {s[STATE_W-2:0], fb};
            word_nxt = {word_nxt[WORD_W-2:0], fb};
        end
        state_nxt = s;
    end

    // Hold the seed under reset or clear, otherwise advance one sample
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q <= SEED;
        end else begin
            state_q <= state_nxt;
        end
    end

    assign word_o = word_nxt;
endmodule

// File: rtl/tpg_phase.sv
// Free-running alternation phase shared by both alternating patterns.
// Reset puts it in the first half; after that it flips on every sample.
module tpg_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    logic phase_q;

    // Flip on every sample, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/tpg_select.sv
// Combinational choice of the next output word from the mode code.
// Assumes DATA_W is even so the checkerboard words are whole bit pairs.
module tpg_select
    import tpg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  tp_mode_e          mode,
    input  logic [DATA_W-1:0] sample,
    input  logic              phase,
    input  logic [DATA_W-1:0] long_word,
    input  logic [DATA_W-1:0] short_word,
    output logic [DATA_W-1:0] word_o
);
    localparam logic [DATA_W-1:0] W_MID   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] W_ONES  = '1;
    localparam logic [DATA_W-1:0] W_ZERO  = '0;
    localparam logic [DATA_W-1:0] W_CHK_A = {(DATA_W/2){2'b10}};
    localparam logic [DATA_W-1:0] W_CHK_B = {(DATA_W/2){2'b01}};

    // Pick live data or the test word for this sample
    always_comb begin
        unique case (mode)
            MODE_LIVE:     word_o = sample;
            MODE_MID:      word_o = W_MID;
            MODE_POS_FS:   word_o = W_ONES;
            MODE_NEG_FS:   word_o = W_ZERO;
            MODE_CHECKER:  word_o = phase ? W_CHK_B : W_CHK_A;
            MODE_PN_LONG:  word_o = long_word;
            MODE_PN_SHORT: word_o = short_word;
            MODE_ONE_ZERO: word_o = phase ? W_ZERO : W_ONES;
            default:       word_o = sample;
        endcase
    end
endmodule

// File: rtl/adc_test_pattern_mux.sv
// Per-channel output test pattern source and multiplexer.
// Holds a long and a short pseudo-random generator (each with its own clear)
// and the alternation phase, and registers the selected word on each sample.
// Assumes one instance per channel; reset is synchronous and active low.
module adc_test_pattern_mux
    import tpg_pkg::*;
#(
    parameter int DATA_W = tpg_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic [2:0]        mode_sel,
    input  logic              pn_long_clr,
    input  logic              pn_short_clr,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] long_word;
    logic [DATA_W-1:0] short_word;
    logic [DATA_W-1:0] next_word;
    logic              phase;
    tp_mode_e          mode;

    assign mode = tp_mode_e'(mode_sel);

    lfsr_word_gen #(
        .STATE_W (LONG_LEN),
        .TAP     (LONG_TAP),
        .WORD_W  (DATA_W)
    ) i_pn_long (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pn_long_clr),
        .word_o (long_word)
    );

    lfsr_word_gen #(
        .STATE_W (SHORT_LEN),
        .TAP     (SHORT_TAP),
        .WORD_W  (DATA_W)
    ) i_pn_short (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pn_short_clr),
        .word_o (short_word)
    );

    tpg_phase i_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    tpg_select #(
        .DATA_W (DATA_W)
    ) i_select (
        .mode       (mode),
        .sample     (sample_in),
        .phase      (phase),
        .long_word  (long_word),
        .short_word (short_word),
        .word_o     (next_word)
    );

    // Register the selected word onto the output bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else begin
            data_out <= next_word;
        end
    end
endmodule

// File: rtl/tpg_checker.sv
// Port-level properties of the test pattern multiplexer, bound to the top.
module tpg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] sample_in,
    input logic [2:0]        mode_sel,
    input logic              pn_long_clr,
    input logic              pn_short_clr,
    input logic [DATA_W-1:0] data_out
);
    AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0) |=> (data_out == $past(sample_in))); // R2

    AST_FIXED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd1) |=> (data_out == 16'h8000)); // R3

    AST_CHECKER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd4 && $past(mode_sel) == 3'd4 && data_out == 16'hAAAA)
        |=> (data_out == 16'h5555)); // R4

    AST_ONE_ZERO_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd7 && $past(mode_sel) == 3'd7 && data_out == 16'hFFFF)
        |=> (data_out == 16'h0000)); // R5

    AST_LONG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd5 && $past(mode_sel) == 3'd5 && pn_long_clr &&
         $past(pn_long_clr) && $past(pn_long_clr, 2))
        |=> $stable(data_out)); // R8

    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd6 && $past(mode_sel) == 3'd6 && pn_short_clr &&
         $past(pn_short_clr) && $past(pn_short_clr, 2))
        |=> $stable(data_out)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n) |=> (data_out == 16'h0000)); // R1
endmodule

bind adc_test_pattern_mux tpg_checker #(.DATA_W(DATA_W)) i_tpg_checker (.*);

// File: tb/test_adc_test_pattern_mux.sv
module test_adc_test_pattern_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sample_in = 16'h0000;
    logic [2:0]  mode_sel = 3'd0;
    logic        pn_long_clr = 1'b0;
    logic        pn_short_clr = 1'b0;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;
    string scen = "";
    bit    done = 1'b0;

    adc_test_pattern_mux i_adc_test_pattern_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_in    (sample_in),
        .mode_sel     (mode_sel),
        .pn_long_clr  (pn_long_clr),
        .pn_short_clr (pn_short_clr),
        .data_out     (data_out)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [22:0] m_long;
    logic [22:0] m_short;
    bit          m_phase;
    logic [15:0] exp_q = 16'h0000;
    string       exp_tag = "R1";

    function automatic logic [15:0] pn_step(input int len, input int tap, inout logic [22:0] st);
        logic [15:0] w = 16'h0;
        logic [22:0] mask = (23'h1 << len) - 23'h1;
        for (int i = 0; i < 16; i++) begin
            logic fb;
            fb = st[len-1] ^ st[tap-1];
            st = ((st << 1) | {22'h0, fb}) & mask;
            w  = {w[14:0], fb};
        end
        return w;
    endfunction

    always @(posedge clk) begin
        logic [15:0] wl, ws;
        logic [22:0] nl, ns;
        if (!rst_n) begin
            exp_q   = 16'h0000;
            exp_tag = "R1";
            m_phase = 0;
            m_long  = 23'h7FFFFF;
            m_short = 23'h0001FF;
        end else begin
            nl = m_long;
            ns = m_short;
            wl = pn_step(23, 18, nl);
            ws = pn_step(9, 5, ns);
            case (mode_sel)
                3'd0: begin exp_q = sample_in; exp_tag = "R2"; end
                3'd1: begin exp_q = 16'h8000; exp_tag = "R3"; end
                3'd2: begin exp_q = 16'hFFFF; exp_tag = "R3"; end
                3'd3: begin exp_q = 16'h0000; exp_tag = "R3"; end
                3'd4: begin exp_q = m_phase ? 16'h5555 : 16'hAAAA; exp_tag = "R4"; end
                3'd5: begin exp_q = wl; exp_tag = "R6"; end
                3'd6: begin exp_q = ws; exp_tag = "R7"; end
                default: begin exp_q = m_phase ? 16'h0000 : 16'hFFFF; exp_tag = "R5"; end
            endcase
            m_phase = !m_phase;
            m_long  = pn_long_clr  ? 23'h7FFFFF : nl;
            m_short = pn_short_clr ? 23'h0001FF : ns;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: data_out=%h expected=%h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge, every clock
    always @(negedge clk) begin
        if (!done && $time > 30) check(exp_tag, data_out, exp_q);
    end

    logic [31:0] lcg = 32'h1234_5678;
    task automatic next_sample();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        sample_in = lcg[31:16];
    endtask

    task automatic run(input int n, input logic [2:0] m);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode_sel = m;
            next_sample();
        end
    endtask

    initial begin
        scen = "reset";
        mode_sel = 3'd2;
        sample_in = 16'hBEEF;
        repeat (4) @(negedge clk);
        check("R1", data_out, 16'h0000);
        rst_n = 1'b1;
        mode_sel = 3'd4;
        scen = "R4 first after reset";
        @(negedge clk);
        check("R4", data_out, 16'hAAAA);
        run(7, 3'd4);
        scen = "live";        run(20, 3'd0);
        scen = "levels";      run(4, 3'd1); run(4, 3'd2); run(4, 3'd3);
        scen = "one-zero";    run(8, 3'd7);
        scen = "long free";   run(30, 3'd5);
        scen = "short free";  run(30, 3'd6);
        // R8: hold long generator at seed, then release
        scen = "R8 long clear";
        @(negedge clk); pn_long_clr = 1'b1; mode_sel = 3'd5;
        repeat (3) @(negedge clk);
        check("R8", data_out, 16'h0000);
        pn_long_clr = 1'b0;
        @(negedge clk);
        check("R8", data_out, 16'h0000);
        run(20, 3'd5);
        scen = "R8 short clear";
        @(negedge clk); pn_short_clr = 1'b1; mode_sel = 3'd6;
        repeat (4) @(negedge clk);
        pn_short_clr = 1'b0;
        run(20, 3'd6);
        // R9: clear the other generator while one is shown
        scen = "R9 short clr in long mode";
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); mode_sel = 3'd5; pn_short_clr = i[2];
        end
        pn_short_clr = 1'b0;
        scen = "R9 long clr in short mode";
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); mode_sel = 3'd6; pn_long_clr = i[1];
        end
        pn_long_clr = 1'b0;
        // R10: mode code changes every sample
        scen = "R10 fast mode change";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); mode_sel = 3'((i * 5 + 3) % 8); next_sample();
        end
        @(negedge clk); mode_sel = 3'd1;
        @(negedge clk);
        check("R10", data_out, 16'h8000);
        mode_sel = 3'd2;
        @(negedge clk);
        check("R10", data_out, 16'hFFFF);
        // R1: reset mid-run
        scen = "R1 reset mid-run";
        rst_n = 1'b0; mode_sel = 3'd6;
        repeat (2) @(negedge clk);
        check("R1", data_out, 16'h0000);
        rst_n = 1'b1;
        run(10, 3'd6);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule